// File: doc/BRIEF.md
# GPIO Transition Interrupt Controller

This block watches the synchronized input values of two general-purpose ports, A (8 bits) and B (7 bits). Every rising or falling change on a pin is captured in a sticky status bit for that pin. Reading a port's status returns the captured bits and clears that port's status in the same cycle. A change that arrives in the cycle of the clearing read is recorded after the clear, so it is not lost.

A per-pin enable decides which status bits can raise the interrupt. The interrupt has one output value. It can drive a level that stays active until software reads the pending status, or a short pulse that repeats while enabled status is still unread. The resting level of the interrupt can be programmed high or low.

The interrupt can take over one of two shared pins: the top bit of port A or the top bit of port B. The block reports which pin it has taken over. On that pin, the transition status always reads zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A rising or falling change on a port pin, seen at a clock edge, sets that pin's status bit. The bit is visible to a read issued in the next cycle.
- R2: A read with `stat_rd` high returns, one cycle later on `stat_rdata`, the selected port's status (select 0 = port A, 1 = port B, zero-extended to 8 bits). It clears only that port's status.
- R3: A change seen in the same cycle as a clearing read of its port is absent from that read's data. It is present in the status afterwards.
- R4: A pin whose enable bit is 0 still records status, but it never makes the interrupt active.
- R5: With `share_irq` low, neither pin-takeover output is high. With `share_irq` high, `share_on_b`=0 takes port A bit 7 and `share_on_b`=1 takes port B bit 6. The two takeover outputs are never both high.
- R6: While a pin carries the interrupt, its status bit reads 0, even if that pin changes.
- R7: While the interrupt is inactive, or `share_irq` is low, `irq_level` equals `irq_idle_high`. The active level is the inverse of `irq_idle_high`.
- R8: In level mode (`irq_pulse_mode`=0), `irq_level` is active in every cycle in which any enabled status bit is set. It returns to idle in the cycle after the read that clears the last such bit.
- R9: In pulse mode, the first pulse starts in the cycle in which enabled status first becomes pending. Each pulse lasts 4 cycles and recurs every 256 cycles until all enabled status has been read.
- R10: In pulse mode, further changes while enabled status is pending do not start a new pulse or restart the 256-cycle spacing.
- R11: After reset, all status is clear, `stat_rdata` is 0, and the pins present at reset are not counted as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pa_pins | input | 8 | Synchronized port A pin values |
| pb_pins | input | 7 | Synchronized port B pin values |
| pa_irq_en | input | 8 | Port A per-pin interrupt enables |
| pb_irq_en | input | 7 | Port B per-pin interrupt enables |
| share_irq | input | 1 | 1: a shared pin carries the interrupt |
| share_on_b | input | 1 | 1: port B bit 6 carries it; 0: port A bit 7 |
| irq_pulse_mode | input | 1 | 1: pulse mode; 0: level mode |
| irq_idle_high | input | 1 | Resting level of the interrupt |
| stat_rd | input | 1 | Status read strobe (clears the selected port) |
| stat_rd_sel | input | 1 | Port selected for the read: 0 = A, 1 = B |
| stat_rdata | output | 8 | Status read data, registered |
| irq_level | output | 1 | Interrupt pin value |
| pa_msb_is_irq | output | 1 | Port A bit 7 carries the interrupt |
| pb_msb_is_irq | output | 1 | Port B bit 6 carries the interrupt |

## Verification
A pin change applied before clock edge N is in the status after edge N. The interrupt therefore leaves its idle level in the sample after N, and `stat_rdata` holds a read strobed before edge N in the sample that follows N. Pulses are due at cycles 0 to 3 and 256 to 259, counted from the edge that made status pending. The bench drives inputs 1 ns after the falling edge and samples at the falling edge. A behavioural reference model advances at each rising edge and is compared with every output on every cycle. Directed checks add fixed expected values and counts of active interrupt cycles over 300-cycle windows.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int RD_W = 8;

   typedef enum logic {
      IRQ_LEVEL = 1'b0,
      IRQ_PULSE = 1'b1
   } irq_mode_e;

   typedef enum logic {
      SEL_PORT_A = 1'b0,
      SEL_PORT_B = 1'b1
   } port_sel_e;

endpackage

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic         clr,
   input  logic [W-1:0] hide,
   output logic [W-1:0] edges,
   output logic [W-1:0] status
);

   generate
      if (W < 1) begin : g_bad_width
         $error("gpio_edge_status: W must be at least 1");
      end
   endgenerate

   logic         armed_q;
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         prev_q  <= '0;
      end else begin
         armed_q <= 1'b1;
         prev_q  <= pins;
      end
   end

   // One flop per pin; a change in the clearing cycle survives the clear.
   genvar b;
   generate
      for (b = 0; b < W; b++) begin : g_bit
         assign edges[b] = armed_q & (pins[b] ^ prev_q[b]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status[b] <= 1'b0;
            end else begin
               status[b] <= ((status[b] & ~clr) | edges[b]) & ~hide[b];
            end
         end
      end
   endgenerate

   AST_EDGE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      (edges != '0) |=> ((status & $past(edges & ~hide)) == $past(edges & ~hide))); // R1

   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((status & ~$past(edges)) == '0)); // R2

   AST_HIDDEN_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hide != '0) |=> ((status & $past(hide)) == '0)); // R6

endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen
   import gpio_irq_pkg::*;
#(
   parameter int PULSE_LEN    = 4,
   parameter int PULSE_PERIOD = 256
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pending,
   input  logic      enable,
   input  irq_mode_e mode,
   input  logic      idle_high,
   output logic      pin
);

   localparam int CNT_W = (PULSE_PERIOD > 2) ? $clog2(PULSE_PERIOD) : 1;

   generate
      if (PULSE_LEN < 1 || PULSE_LEN >= PULSE_PERIOD) begin : g_bad_pulse
         $error("gpio_irq_gen: need 1 <= PULSE_LEN < PULSE_PERIOD");
      end
   endgenerate

   logic [CNT_W-1:0] phase_q;
   logic             active;

   // Phase runs only while pending; a fresh pending starts a pulse at once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!pending) begin
         phase_q <= '0;
      end else if (phase_q == CNT_W'(PULSE_PERIOD - 1)) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   always_comb begin
      if (mode == IRQ_PULSE) begin
         active = pending && (phase_q < CNT_W'(PULSE_LEN));
      end else begin
         active = pending;
      end
   end

   assign pin = idle_high ^ (enable & active);

   AST_QUIET_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> (pin == idle_high)); // R7

   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == IRQ_LEVEL && pending) |-> (pin != idle_high)); // R8

   AST_PULSE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == IRQ_PULSE && $rose(pending)) |-> (pin != idle_high)); // R9

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int PA_W         = 8,
   parameter int PB_W         = 7,
   parameter int PULSE_LEN    = 4,
   parameter int PULSE_PERIOD = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PA_W-1:0] pa_pins,
   input  logic [PB_W-1:0] pb_pins,
   input  logic [PA_W-1:0] pa_irq_en,
   input  logic [PB_W-1:0] pb_irq_en,
   input  logic            share_irq,
   input  logic            share_on_b,
   input  logic            irq_pulse_mode,
   input  logic            irq_idle_high,
   input  logic            stat_rd,
   input  logic            stat_rd_sel,
   output logic [RD_W-1:0] stat_rdata,
   output logic            irq_level,
   output logic            pa_msb_is_irq,
   output logic            pb_msb_is_irq
);

   localparam logic [PA_W-1:0] PA_TOP = PA_W'(1) << (PA_W - 1);
   localparam logic [PB_W-1:0] PB_TOP = PB_W'(1) << (PB_W - 1);

   generate
      if (PA_W > RD_W || PB_W > RD_W) begin : g_bad_port
         $error("gpio_irq_ctrl: port widths must fit the read data");
      end
   endgenerate

   port_sel_e       sel;
   logic [PA_W-1:0] pa_hide, pa_edges, pa_status;
   logic [PB_W-1:0] pb_hide, pb_edges, pb_status;
   logic            pending;

   assign sel           = port_sel_e'(stat_rd_sel);
   assign pa_msb_is_irq = share_irq & ~share_on_b;
   assign pb_msb_is_irq = share_irq &  share_on_b;
   assign pa_hide       = pa_msb_is_irq ? PA_TOP : '0;
   assign pb_hide       = pb_msb_is_irq ? PB_TOP : '0;

   gpio_edge_status #(.W(PA_W)) u_port_a (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins   (pa_pins),
      .clr    (stat_rd && sel == SEL_PORT_A),
      .hide   (pa_hide),
      .edges  (pa_edges),
      .status (pa_status)
   );

   gpio_edge_status #(.W(PB_W)) u_port_b (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins   (pb_pins),
      .clr    (stat_rd && sel == SEL_PORT_B),
      .hide   (pb_hide),
      .edges  (pb_edges),
      .status (pb_status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_rdata <= '0;
      end else if (stat_rd) begin
         if (sel == SEL_PORT_B) stat_rdata <= RD_W'(pb_status & ~pb_hide);
         else                   stat_rdata <= RD_W'(pa_status & ~pa_hide);
      end
   end

   assign pending = |(pa_status & pa_irq_en & ~pa_hide)
                  | |(pb_status & pb_irq_en & ~pb_hide);

   gpio_irq_gen #(
      .PULSE_LEN    (PULSE_LEN),
      .PULSE_PERIOD (PULSE_PERIOD)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (pending),
      .enable    (share_irq),
      .mode      (irq_mode_e'(irq_pulse_mode)),
      .idle_high (irq_idle_high),
      .pin       (irq_level)
   );

   AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pa_msb_is_irq, pb_msb_is_irq})); // R5

   AST_READ_HIDES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && sel == SEL_PORT_A && pa_msb_is_irq) |=> !stat_rdata[PA_W-1]); // R6

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_irq_en == '0 && pb_irq_en == '0) |-> (irq_level == irq_idle_high)); // R4

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

   localparam int PA_W = 8;
   localparam int PB_W = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PA_W-1:0] pa_pins = '0;
   logic [PB_W-1:0] pb_pins = '0;
   logic [PA_W-1:0] pa_irq_en = '1;
   logic [PB_W-1:0] pb_irq_en = '1;
   logic            share_irq = 1'b1;
   logic            share_on_b = 1'b0;
   logic            irq_pulse_mode = 1'b0;
   logic            irq_idle_high = 1'b0;
   logic            stat_rd = 1'b0;
   logic            stat_rd_sel = 1'b0;
   logic [7:0]      stat_rdata;
   logic            irq_level;
   logic            pa_msb_is_irq;
   logic            pb_msb_is_irq;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R11";

   always #2.5 clk = ~clk;

   gpio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pa_pins(pa_pins), .pb_pins(pb_pins),
      .pa_irq_en(pa_irq_en), .pb_irq_en(pb_irq_en), .share_irq(share_irq),
      .share_on_b(share_on_b), .irq_pulse_mode(irq_pulse_mode),
      .irq_idle_high(irq_idle_high), .stat_rd(stat_rd), .stat_rd_sel(stat_rd_sel),
      .stat_rdata(stat_rdata), .irq_level(irq_level),
      .pa_msb_is_irq(pa_msb_is_irq), .pb_msb_is_irq(pb_msb_is_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_pa_prev, m_pb_prev, m_st_a, m_st_b, m_rd, m_cnt;
   bit m_armed;

   function automatic int hide_a();
      return (share_irq && !share_on_b) ? 'h80 : 0;
   endfunction
   function automatic int hide_b();
      return (share_irq && share_on_b) ? 'h40 : 0;
   endfunction
   function automatic bit m_pend();
      return ((m_st_a & int'(pa_irq_en) & ~hide_a()) != 0) ||
             ((m_st_b & int'(pb_irq_en) & ~hide_b()) != 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pa_prev = 0; m_pb_prev = 0; m_st_a = 0; m_st_b = 0;
         m_rd = 0; m_cnt = 0; m_armed = 0;
      end else begin
         int ea, eb, na, nb;
         m_cnt = m_pend() ? (m_cnt + 1) % 256 : 0;
         ea = m_armed ? (int'(pa_pins) ^ m_pa_prev) : 0;
         eb = m_armed ? (int'(pb_pins) ^ m_pb_prev) : 0;
         if (stat_rd) m_rd = stat_rd_sel ? (m_st_b & ~hide_b()) : (m_st_a & ~hide_a());
         na = (stat_rd && !stat_rd_sel) ? 0 : m_st_a;
         nb = (stat_rd &&  stat_rd_sel) ? 0 : m_st_b;
         m_st_a = (na | ea) & ~hide_a() & 'hFF;
         m_st_b = (nb | eb) & ~hide_b() & 'h7F;
         m_pa_prev = int'(pa_pins);
         m_pb_prev = int'(pb_pins);
         m_armed = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit act;
         act = m_pend() && (irq_pulse_mode ? (m_cnt < 4) : 1'b1);
         chk({cur_req, " model irq"}, int'(irq_level), int'(irq_idle_high ^ (share_irq & act)));
         chk({cur_req, " model rdata"}, int'(stat_rdata), m_rd);
         chk("R5 model route", int'({pa_msb_is_irq, pb_msb_is_irq}),
             int'({share_irq & ~share_on_b, share_irq & share_on_b}));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic drive_next();
      @(negedge clk); #1;
   endtask

   // Read a port; returns the data visible after the read edge.
   task automatic read_port(input bit port_b, output int data);
      drive_next();
      stat_rd = 1'b1; stat_rd_sel = port_b;
      @(negedge clk);
      data = int'(stat_rdata);
      #1 stat_rd = 1'b0;
   endtask

   task automatic count_active(input int n, output int hits);
      hits = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (irq_level != irq_idle_high) hits++;
      end
   endtask

   initial begin
      int d, hits, hits2;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rdata after reset", int'(stat_rdata), 0);
      chk("R11 irq idle after reset", int'(irq_level), 0);
      chk("R5 port A takes irq", int'(pa_msb_is_irq), 1);

      // R1 / R8 level mode
      cur_req = "R8";
      drive_next(); pa_pins[0] = 1'b1;
      @(negedge clk);
      chk("R8 level active after change", int'(irq_level), 1);
      read_port(1'b0, d);
      chk("R1 status bit 0 set", d, 'h01);
      chk("R8 level idle after read", int'(irq_level), 0);

      // R2 port isolation
      cur_req = "R2";
      drive_next(); pa_pins[2] = 1'b1; pb_pins[1] = 1'b1;
      read_port(1'b0, d);
      chk("R2 port A data", d, 'h04);
      read_port(1'b1, d);
      chk("R2 port B untouched by A read", d, 'h02);
      read_port(1'b1, d);
      chk("R2 port B cleared", d, 0);

      // R6 hidden pin
      cur_req = "R6";
      drive_next(); pa_pins[7] = 1'b1;
      read_port(1'b0, d);
      chk("R6 port A bit 7 reads 0", d, 0);
      drive_next(); share_on_b = 1'b1;
      @(negedge clk);
      chk("R5 port B takes irq", int'({pa_msb_is_irq, pb_msb_is_irq}), 1);
      drive_next(); pa_pins[7] = 1'b0; pb_pins[6] = 1'b1;
      read_port(1'b0, d);
      chk("R6 port A bit 7 visible again", d, 'h80);
      read_port(1'b1, d);
      chk("R6 port B bit 6 reads 0", d, 0);
      drive_next(); share_on_b = 1'b0; share_irq = 1'b0;
      @(negedge clk);
      chk("R5 no takeover", int'({pa_msb_is_irq, pb_msb_is_irq}), 0);
      drive_next(); share_irq = 1'b1;

      // R3 change coincident with clearing read
      cur_req = "R3";
      drive_next(); pa_pins[3] = 1'b1; stat_rd = 1'b1; stat_rd_sel = 1'b0;
      @(negedge clk);
      chk("R3 read excludes same-cycle change", int'(stat_rdata), 0);
      #1 stat_rd = 1'b0;
      read_port(1'b0, d);
      chk("R3 change kept after clear", d, 'h08);

      // R4 disabled pins
      cur_req = "R4";
      drive_next(); pa_irq_en = '0; pb_irq_en = '0; pa_pins[1] = 1'b1;
      count_active(5, hits);
      chk("R4 disabled pin gives no irq", hits, 0);
      read_port(1'b0, d);
      chk("R4 status still recorded", d, 'h02);
      drive_next(); pa_irq_en = '1; pb_irq_en = '1;

      // R7 idle-high polarity
      cur_req = "R7";
      drive_next(); irq_idle_high = 1'b1;
      @(negedge clk);
      chk("R7 idle high", int'(irq_level), 1);
      drive_next(); pa_pins[4] = 1'b1;
      @(negedge clk);
      chk("R7 active low", int'(irq_level), 0);
      read_port(1'b0, d);
      chk("R7 back to idle high", int'(irq_level), 1);
      drive_next(); irq_idle_high = 1'b0; irq_pulse_mode = 1'b1;

      // R9 pulse train
      cur_req = "R9";
      drive_next(); pa_pins[5] = 1'b1;
      count_active(300, hits);
      chk("R9 two pulses of 4 in 300 cycles", hits, 8);
      read_port(1'b0, d);
      chk("R9 read data", d, 'h20);
      count_active(300, hits);
      chk("R9 no pulses after read", hits, 0);

      // R10 no restart while pending
      cur_req = "R10";
      drive_next(); pa_pins[6] = 1'b1;
      count_active(99, hits);
      @(negedge clk);
      if (irq_level != irq_idle_high) hits++;
      #1 pb_pins[0] = 1'b1;
      count_active(200, hits2);
      chk("R10 first pulse only at start", hits, 4);
      chk("R10 later change keeps spacing", hits2, 4);
      read_port(1'b0, d);
      read_port(1'b1, d);
      chk("R10 port B data", d, 'h01);

      drive_next();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule